// File: doc/BRIEF.md
# Byte-wide SPI serial port with sticky overflow and collision status

This block is a byte-wide SPI port controlled through a small register port. An 8-bit control word selects enable, clock idle level and mode, and holds two sticky error flags. A single 8-bit holding buffer is shared by both directions. A write loads the byte to be sent next, and a read returns the last byte received. A shift register moves bits on SDI and SDO, most significant bit first. In slave mode the external SCK is resynchronised to the system clock. In master mode the block makes its own SCK from a fixed divider, and each transfer starts when the buffer is written.

The block raises two error flags. If a byte completes while the buffer still holds an unread byte, the new byte is dropped and the overflow flag is raised. If the buffer is written while a transfer is in progress, the write is refused and the collision flag is raised. Each flag stays set until the host writes a 0 to it.

The register port has no back-pressure. Writes and reads take effect in the cycle where the strobe is high, and read data is combinational from the address. For this reason the flow of data is handled with the buffer-full flag rather than a valid/ready handshake. The host must drain the buffer before the next byte completes. Each pin output comes with its own drive-enable, so the enclosing pad logic sets the high-impedance state.

Top module: `spi_serial_port`

## Requirements
- R1: After reset the control word reads 8'h00, `buf_full` is 0, and both `spi_sck_oe` and `spi_sdo_oe` are 0.
- R2: The control word is at address 0 and the buffer is at address 1. In the control word, bit 7 is the collision flag, bit 6 is the overflow flag, bit 5 is the enable, bit 4 is the clock idle level, and bits 3:0 are the mode. Mode 4'b0000 is master and any other value is slave. A host write never sets bit 7 or bit 6.
- R3: In slave mode, SDI is sampled on each SCK edge that leaves the idle level, most significant bit first. After the eighth such edge the byte is placed in the buffer and `buf_full` rises. A read at address 1 returns that byte and clears `buf_full`.
- R4: A byte written to the buffer while no transfer is running is sent on SDO, most significant bit first. The first bit is present before the first leading edge, and SDO moves to the next bit after each edge that returns SCK to idle.
- R5: In slave mode, if a byte completes while `buf_full` is 1, the overflow flag (bit 6) is set, the new byte is dropped and the buffer keeps its old contents.
- R6: A buffer write while a transfer is in progress sets the collision flag (bit 7). The written value is discarded, and the byte being sent continues unchanged.
- R7: Both flags stay set until a control write with a 0 in that bit position. Writing a 1 to a set flag leaves it set.
- R8: With the idle level at 1, SCK idles high, the falling edge samples and the rising edge shifts. Data is received and sent exactly as with idle level 0.
- R9: In slave mode, a high `spi_ss_n` returns the bit counter to zero, so a broken transfer is abandoned. `spi_sdo_oe` is 0 while select is high.
- R10: With enable 0, `spi_sck_oe` and `spi_sdo_oe` are 0 and no byte is received.
- R11: In master mode, a buffer write starts eight SCK pulses on `spi_sck_o` with `spi_sck_oe` high. SCK idles at the selected idle level. The received byte is always placed in the buffer and the overflow flag is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 1 | 0 = control word, 1 = holding buffer |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe; at address 1 it clears `buf_full` |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| buf_full | output | 1 | Received byte waiting in the buffer |
| spi_sck_i | input | 1 | Serial clock from an external master |
| spi_sck_o | output | 1 | Serial clock generated in master mode |
| spi_sck_oe | output | 1 | Drive enable for `spi_sck_o` |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial data out |
| spi_sdo_oe | output | 1 | Drive enable for `spi_sdo` |
| spi_ss_n | input | 1 | Active-low slave select |

## Verification
In slave mode, each input pin passes through two synchroniser stages and one edge-detect cycle. A shift or capture therefore lands three or four system cycles after the pin moves, and `buf_full` or a flag rises one cycle later. The bench keeps every SCK phase at least six cycles long and samples SDO only just before it drives the next leading edge. Select reaches `spi_sdo_oe` two cycles after the pin, so the bench waits four cycles before checking it. Register writes show in a read one cycle later. In master mode, a whole byte takes sixteen half periods of the divider plus a few cycles, and the bench waits well past that before reading the buffer.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int unsigned DATA_W = 8;
  localparam logic        ADDR_CTRL = 1'b0;
  localparam logic        ADDR_BUF  = 1'b1;
  localparam logic [3:0]  MODE_MASTER = 4'b0000;

  typedef struct packed {
    logic       wcol;
    logic       ovf;
    logic       en;
    logic       cpol;
    logic [3:0] mode;
  } ctrl_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic sdi,
  input  logic ss_n,
  input  logic cpol,
  output logic sdi_s,
  output logic ss_n_s,
  output logic lead,
  output logic trail
);
  logic [STAGES-1:0] sck_q, sdi_q, ss_q;
  logic              sck_prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          sck_q <= '0; sdi_q <= '0; ss_q <= '1;
        end else begin
          sck_q <= sck; sdi_q <= sdi; ss_q <= ss_n;
        end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          sck_q <= '0; sdi_q <= '0; ss_q <= '1;
        end else begin
          sck_q <= {sck_q[STAGES-2:0], sck};
          sdi_q <= {sdi_q[STAGES-2:0], sdi};
          ss_q  <= {ss_q[STAGES-2:0], ss_n};
        end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_q[STAGES-1];

  assign sdi_s  = sdi_q[STAGES-1];
  assign ss_n_s = ss_q[STAGES-1];
  assign lead   = (sck_q[STAGES-1] != sck_prev) && (sck_q[STAGES-1] != cpol);
  assign trail  = (sck_q[STAGES-1] != sck_prev) && (sck_q[STAGES-1] == cpol);
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int unsigned HALF = 4,
  parameter int unsigned BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start,
  input  logic cpol,
  output logic sck_o,
  output logic active,
  output logic lead,
  output logic trail
);
  localparam int unsigned DW = $clog2(HALF + 1);
  localparam int unsigned EW = $clog2(2 * BITS + 1);

  logic [DW-1:0] div_cnt;
  logic [EW-1:0] edges;
  logic          phase;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0; phase <= 1'b0; div_cnt <= '0; edges <= '0;
      lead <= 1'b0; trail <= 1'b0;
    end else begin
      lead  <= 1'b0;
      trail <= 1'b0;
      if (!enable) begin
        active <= 1'b0; phase <= 1'b0; div_cnt <= '0; edges <= '0;
      end else if (start && !active) begin
        active <= 1'b1; phase <= 1'b0; div_cnt <= '0; edges <= '0;
      end else if (active) begin
        if (div_cnt == DW'(HALF - 1)) begin
          div_cnt <= '0;
          phase   <= ~phase;
          lead    <= ~phase;
          trail   <= phase;
          edges   <= edges + 1'b1;
          if (edges == EW'(2 * BITS - 1)) active <= 1'b0;
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end

  assign sck_o = cpol ^ phase;

  a_r11_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (sck_o == cpol));
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         lead,
  input  logic         trail,
  input  logic         sdi,
  output logic         sdo,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_byte
);
  localparam int unsigned CW = $clog2(W);

  logic [W-1:0]  sr;
  logic [CW-1:0] cnt;
  logic          cap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr <= '0; cnt <= '0; cap <= 1'b0; busy <= 1'b0; done <= 1'b0; rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (load && !busy) sr <= load_data;
      if (clear) begin
        cnt <= '0; busy <= 1'b0;
      end else if (lead) begin
        cap <= sdi;
        if (cnt == CW'(W - 1)) begin
          cnt     <= '0;
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_byte <= {sr[W-2:0], sdi};
        end else begin
          cnt  <= cnt + 1'b1;
          busy <= 1'b1;
        end
      end else if (trail && busy) begin
        sr <= {sr[W-2:0], cap};
      end
    end

  assign sdo = sr[W-1];

  a_r9_count_reset: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0) && !busy);
endmodule

// File: rtl/spi_serial_port.sv
module spi_serial_port
  import spi_port_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MASTER_HALF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              buf_full,
  input  logic              spi_sck_i,
  output logic              spi_sck_o,
  output logic              spi_sck_oe,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  input  logic              spi_ss_n
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] buf_q;
  logic              is_master, wr_ctrl, wr_buf, rd_buf;
  logic              sdi_s, ss_n_s, s_lead, s_trail;
  logic              g_lead, g_trail, g_active;
  logic              lead, trail, sh_busy, done, clear, xfer_busy, accept;
  logic [DATA_W-1:0] rx_byte;

  assign is_master = (ctrl_q.mode == MODE_MASTER);
  assign wr_ctrl   = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_buf    = reg_wr && (reg_addr == ADDR_BUF);
  assign rd_buf    = reg_rd && (reg_addr == ADDR_BUF);
  assign xfer_busy = sh_busy || g_active;
  assign accept    = wr_buf && ctrl_q.en && !xfer_busy;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck_i), .sdi(spi_sdi), .ss_n(spi_ss_n),
    .cpol(ctrl_q.cpol), .sdi_s(sdi_s), .ss_n_s(ss_n_s), .lead(s_lead), .trail(s_trail));

  spi_sck_gen #(.HALF(MASTER_HALF), .BITS(DATA_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .enable(ctrl_q.en && is_master),
    .start(accept && is_master), .cpol(ctrl_q.cpol), .sck_o(spi_sck_o),
    .active(g_active), .lead(g_lead), .trail(g_trail));

  assign lead  = ctrl_q.en && (is_master ? g_lead  : s_lead);
  assign trail = ctrl_q.en && (is_master ? g_trail : s_trail);
  assign clear = !ctrl_q.en || (!is_master && ss_n_s);

  spi_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load(accept), .load_data(reg_wdata),
    .lead(lead), .trail(trail), .sdi(sdi_s), .sdo(spi_sdo), .busy(sh_busy),
    .done(done), .rx_byte(rx_byte));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q <= '0; buf_q <= '0; buf_full <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.en   <= reg_wdata[5];
        ctrl_q.cpol <= reg_wdata[4];
        ctrl_q.mode <= reg_wdata[3:0];
        ctrl_q.wcol <= ctrl_q.wcol & reg_wdata[7];
        ctrl_q.ovf  <= ctrl_q.ovf  & reg_wdata[6];
      end
      if (wr_buf && ctrl_q.en && xfer_busy) ctrl_q.wcol <= 1'b1;
      if (rd_buf) buf_full <= 1'b0;
      if (done) begin
        if (!is_master && buf_full) begin
          ctrl_q.ovf <= 1'b1;
        end else begin
          buf_q    <= rx_byte;
          buf_full <= 1'b1;
        end
      end
    end

  assign reg_rdata  = (reg_addr == ADDR_BUF) ? buf_q : ctrl_q;
  assign spi_sck_oe = ctrl_q.en && is_master;
  assign spi_sdo_oe = ctrl_q.en && (is_master || !ss_n_s);

  a_r3_full_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_master && !buf_full) |=> buf_full);
  a_r5_overflow_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_master && buf_full) |=> ctrl_q.ovf && $stable(buf_q));
  a_r6_collision_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_buf && ctrl_q.en && xfer_busy) |=> ctrl_q.wcol);
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.ovf && !(wr_ctrl && !reg_wdata[6])) |=> ctrl_q.ovf);
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && !ctrl_q.ovf) |=> !ctrl_q.ovf);
endmodule

// File: tb/spi_serial_port_bench.sv
module spi_serial_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_addr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic buf_full, spi_sck_o, spi_sck_oe, spi_sdo, spi_sdo_oe;
  logic sck_drv = 1'b0, sdi_drv = 1'b0, ss_drv = 1'b1, loop = 1'b0;
  logic cp = 1'b0;
  int   n_chk = 0, n_bad = 0, sck_rises = 0;
  bit   done_flag = 1'b0;

  always #2 clk = ~clk;

  spi_serial_port u_spi_serial_port (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .buf_full(buf_full), .spi_sck_i(sck_drv), .spi_sck_o(spi_sck_o),
    .spi_sck_oe(spi_sck_oe), .spi_sdi(loop ? spi_sdo : sdi_drv),
    .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe), .spi_ss_n(ss_drv));

  always @(posedge spi_sck_o) if (spi_sck_oe) sck_rises++;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic shift_bit(input logic b, output logic o);
    o = spi_sdo; sdi_drv = b;
    repeat (4) @(negedge clk); sck_drv = ~cp;
    repeat (6) @(negedge clk); sck_drv = cp;
    repeat (6) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] mosi, output logic [7:0] miso);
    ss_drv = 1'b0; repeat (4) @(negedge clk);
    for (int i = 7; i >= 0; i--) shift_bit(mosi[i], miso[i]);
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // {mosi, tx byte, idle level}
  localparam logic [16:0] VEC [4] = '{
    {8'hA5, 8'h3C, 1'b0}, {8'h01, 8'h80, 1'b0},
    {8'hFF, 8'h00, 1'b1}, {8'h5A, 8'hC3, 1'b1}};

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] d, m;
    repeat (3) @(negedge clk); rst_n = 1'b1; @(negedge clk);
    rd(1'b0, d);
    check("R1 ctrl", d, 8'h00);
    check("R1 full/oe", {5'b0, buf_full, spi_sck_oe, spi_sdo_oe}, 8'h00);

    wr(1'b0, 8'hFF); rd(1'b0, d);
    check("R2 flags not host-settable", d, 8'h3F);

    for (int v = 0; v < 4; v++) begin
      cp = VEC[v][0]; sck_drv = cp;
      wr(1'b0, {4'b0010, 3'b000, cp} << 0 | 8'h24 | (cp ? 8'h10 : 8'h00));
      repeat (4) @(negedge clk);
      wr(1'b1, VEC[v][8:1]);
      xfer(VEC[v][16:9], m);
      ss_drv = 1'b1;
      check(cp ? "R8 miso idle-high" : "R4 miso", m, VEC[v][8:1]);
      check("R3 full after byte", {7'b0, buf_full}, 8'h01);
      rd(1'b1, d);
      check(cp ? "R8 mosi idle-high" : "R3 mosi", d, VEC[v][16:9]);
      @(negedge clk);
      check("R3 read clears full", {7'b0, buf_full}, 8'h00);
      repeat (4) @(negedge clk);
    end

    cp = 1'b0; sck_drv = 1'b0; wr(1'b0, 8'h24); repeat (4) @(negedge clk);
    check("R9 sdo hi-z deselected", {7'b0, spi_sdo_oe}, 8'h00);
    ss_drv = 1'b0; repeat (4) @(negedge clk);
    check("R9 sdo driven selected", {7'b0, spi_sdo_oe}, 8'h01);
    for (int i = 0; i < 3; i++) shift_bit(1'b1, m[0]);
    ss_drv = 1'b1; repeat (6) @(negedge clk);
    xfer(8'h69, m); ss_drv = 1'b1;
    rd(1'b1, d);
    check("R9 count restarts", d, 8'h69);

    xfer(8'h11, m); ss_drv = 1'b1; repeat (4) @(negedge clk);
    xfer(8'h22, m); ss_drv = 1'b1;
    rd(1'b0, d);
    check("R5 overflow flag", {7'b0, d[6]}, 8'h01);
    rd(1'b1, d);
    check("R5 old byte kept", d, 8'h11);

    wr(1'b0, 8'h64); rd(1'b0, d);
    check("R7 write 1 keeps ovf", {7'b0, d[6]}, 8'h01);
    wr(1'b0, 8'h24); rd(1'b0, d);
    check("R7 write 0 clears ovf", {7'b0, d[6]}, 8'h00);

    wr(1'b1, 8'hB2);
    ss_drv = 1'b0; repeat (4) @(negedge clk);
    for (int i = 7; i >= 5; i--) shift_bit(1'b0, m[i]);
    wr(1'b1, 8'h0F);
    rd(1'b0, d);
    check("R6 collision flag", {7'b0, d[7]}, 8'h01);
    for (int i = 4; i >= 0; i--) shift_bit(1'b0, m[i]);
    ss_drv = 1'b1;
    check("R6 tx unchanged", m, 8'hB2);
    rd(1'b1, d);
    wr(1'b0, 8'h24); rd(1'b0, d);
    check("R7 write 0 clears wcol", {7'b0, d[7]}, 8'h00);

    wr(1'b0, 8'h04);
    xfer(8'h77, m); ss_drv = 1'b1;
    check("R10 disabled quiet", {5'b0, buf_full, spi_sck_oe, spi_sdo_oe}, 8'h00);

    wr(1'b0, 8'h24);
    xfer(8'h33, m); ss_drv = 1'b1;
    loop = 1'b1;
    wr(1'b0, 8'h20); @(negedge clk);
    check("R11 sck driven", {7'b0, spi_sck_oe}, 8'h01);
    sck_rises = 0;
    wr(1'b1, 8'h96);
    repeat (100) @(negedge clk);
    check("R11 eight pulses", sck_rises[7:0], 8'd8);
    rd(1'b0, d);
    check("R11 no overflow", {7'b0, d[6]}, 8'h00);
    rd(1'b1, d);
    check("R11 loopback byte", d, 8'h96);
    wr(1'b0, 8'h30); @(negedge clk);
    check("R11 idle level high", {7'b0, spi_sck_o}, 8'h01);
    loop = 1'b0;
    finish_run();
  end
endmodule